// File: doc/BRIEF.md
# Indirect Transmit Queue Context Access Port

This block gives a host access, through a small register window, to a store of per-queue transmit contexts. Each context is ten 32-bit words (40 bytes). The host does not address the store directly. It stages a whole context in a bank of ten data registers. It then writes one control word that names a queue, selects a command and sets an execute bit. The block then moves data between the staging bank and the chosen store entry, one word per clock.

Four commands are defined. A read copies an entry into the staging bank. A full write copies the bank into the entry. A partial write replaces only the configuration bytes and keeps the live state bytes. A clear zeroes the entry. The queue named in the control word is a local index. The block adds it to a per-function base queue number to get the physical entry. While an operation runs, the execute bit reads back as set and the staging bank is locked against host writes.

Top module: `qctx_access_unit`

## Requirements
- R1: The control word is at host word address 10. It has the local queue index in bits 13:0, the command in bits 18:16 and execute in bit 19. A read of it returns the last written index and command, with bit 19 showing the busy state. A write with bit 19 clear records the fields and starts nothing.
- R2: Staging data words sit at host word addresses 0 to 9. Addresses 11 and above read as zero. After reset, every data word, the control word and every store entry are zero.
- R3: Command 1 (full write) copies all ten staging words into the selected entry.
- R4: After the clock edge that captures an execute, the block is busy for exactly ten cycles. Host writes to the staging words during that time are ignored.
- R5: Command 0 (read) copies all ten words of the selected entry into the staging words.
- R6: Command 4 (partial write) updates only the static bits, which are the low 22 bytes: words 0 to 4 in full and bits 15:0 of word 5. Every other bit of the entry keeps its stored value.
- R7: Command 3 (clear) sets every bit of the selected entry to zero.
- R8: Any other command code (2, 5, 6, 7) runs its busy period but changes no entry and no staging word.
- R9: The physical entry is the base queue input plus the local index, modulo 2^14. If the result is not below the number of stored queues, the operation changes no entry and no staging word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe for the addressed register |
| host_addr | input | ADDR_W (4) | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| base_qid | input | QID_W (14) | Base physical queue number of the accessing function |

## Verification
The bench builds the block with four stored queues and keeps the default ten-word context. With only four entries, both a local index beyond the store and a base-plus-index sum beyond it can be reached with small numbers. The bench also sets a nonzero base, so offset addressing is observed through a later access to the same physical entry with base zero. Ten words per context keep the partial-write boundary inside word 5, where it splits the word in half.

// File: rtl/qctx_pkg.sv
package qctx_pkg;

  localparam int CTX_DW     = 32;
  localparam int QIDX_LSB   = 0;
  localparam int CMD_LSB    = 16;
  localparam int CMD_W      = 3;
  localparam int EXEC_POS   = 19;

  typedef enum logic [CMD_W-1:0] {
    QC_READ    = 3'd0,
    QC_WRITE   = 3'd1,
    QC_CLEAR   = 3'd3,
    QC_KEEPDYN = 3'd4
  } qc_cmd_e;

  function automatic logic cmd_defined(input logic [CMD_W-1:0] c);
    return (c == QC_READ) || (c == QC_WRITE) ||
           (c == QC_CLEAR) || (c == QC_KEEPDYN);
  endfunction

  // bits of context word 'wi' that belong to the first 'nbytes' bytes
  function automatic logic [CTX_DW-1:0] static_bits(input int wi, input int nbytes);
    logic [CTX_DW-1:0] m;
    for (int b = 0; b < CTX_DW; b++) begin
      m[b] = ((wi * CTX_DW + b) < (nbytes * 8));
    end
    return m;
  endfunction

endpackage

// File: rtl/qctx_ctrl.sv
module qctx_ctrl
  import qctx_pkg::*;
#(
  parameter int NUM_Q = 8,
  parameter int WORDS = 10,
  parameter int QID_W = 14,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [CTX_DW-1:0]    ctl_wdata,
  input  logic [QID_W-1:0]     base_qid,
  output logic                 busy,
  output logic [CMD_W-1:0]     op_cmd,
  output logic                 op_hit,
  output logic [IDX_W-1:0]     op_idx,
  output logic [CNT_W-1:0]     word_idx,
  output logic [CTX_DW-1:0]    ctl_rdata
);

  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic [QID_W-1:0]   lqid_q, lqid_d;
  logic               hit_q, hit_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [QID_W-1:0]   phys;
  logic               fld_en, go, last;

  assign phys   = base_qid + ctl_wdata[QIDX_LSB +: QID_W];
  assign fld_en = ctl_we & ~busy_q;
  assign go     = fld_en & ctl_wdata[EXEC_POS];
  assign last   = (cnt_q == CNT_W'(WORDS - 1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cmd_d  = cmd_q;
    lqid_d = lqid_q;
    hit_d  = hit_q;
    idx_d  = idx_q;
    if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end else if (fld_en) begin
      cmd_d  = ctl_wdata[CMD_LSB +: CMD_W];
      lqid_d = ctl_wdata[QIDX_LSB +: QID_W];
      if (go) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        hit_d  = cmd_defined(ctl_wdata[CMD_LSB +: CMD_W]) &&
                 (32'(phys) < 32'(NUM_Q));
        idx_d  = phys[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      lqid_q <= '0;
      hit_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      cmd_q  <= cmd_d;
      lqid_q <= lqid_d;
      hit_q  <= hit_d;
      idx_q  <= idx_d;
    end
  end

  assign busy     = busy_q;
  assign op_cmd   = cmd_q;
  assign op_hit   = hit_q;
  assign op_idx   = idx_q;
  assign word_idx = cnt_q;

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[QIDX_LSB +: QID_W] = lqid_q;
    ctl_rdata[CMD_LSB +: CMD_W]  = cmd_q;
    ctl_rdata[EXEC_POS]          = busy_q;
  end

  a_r4_exec_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_we && ctl_wdata[EXEC_POS]) |=> (busy && word_idx == '0));

  a_r4_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && word_idx == CNT_W'(WORDS - 1)) |=> !busy);

  a_r1_no_exec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(ctl_we && ctl_wdata[EXEC_POS])) |=> !busy);

  a_r8_undef_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !cmd_defined(op_cmd)) |-> !op_hit);

endmodule

// File: rtl/qctx_stage.sv
module qctx_stage
  import qctx_pkg::*;
#(
  parameter int WORDS  = 10,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_we,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [CTX_DW-1:0]    host_wdata,
  input  logic                 busy,
  input  logic                 load_en,
  input  logic [CNT_W-1:0]     load_idx,
  input  logic [CTX_DW-1:0]    load_word,
  output logic [CTX_DW-1:0]    host_word,
  output logic [CTX_DW-1:0]    op_word
);

  logic [WORDS-1:0][CTX_DW-1:0] bank_q, bank_d;
  logic host_en;

  assign host_en = host_we & ~busy & (32'(host_addr) < 32'(WORDS));

  always_comb begin
    bank_d = bank_q;
    if (load_en) begin
      bank_d[load_idx] = load_word;
    end else if (host_en) begin
      bank_d[host_addr] = host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else begin
      bank_q <= bank_d;
    end
  end

  assign host_word = (32'(host_addr) < 32'(WORDS)) ? bank_q[host_addr] : '0;
  assign op_word   = bank_q[load_idx];

  a_r4_bank_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load_en) |=> $stable(bank_q));

endmodule

// File: rtl/qctx_store.sv
module qctx_store
  import qctx_pkg::*;
#(
  parameter int NUM_Q      = 8,
  parameter int WORDS      = 10,
  parameter int STAT_BYTES = 22,
  parameter int IDX_W      = 3,
  parameter int CNT_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 hit,
  input  logic [CMD_W-1:0]     cmd,
  input  logic [IDX_W-1:0]     idx,
  input  logic [CNT_W-1:0]     widx,
  input  logic [CTX_DW-1:0]    stage_word,
  output logic [CTX_DW-1:0]    rd_word
);

  logic [NUM_Q-1:0][WORDS-1:0][CTX_DW-1:0] mem_q;
  logic [CTX_DW-1:0] keep_mask, new_word;
  logic              we;

  always_comb begin
    keep_mask = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (widx == CNT_W'(w)) keep_mask = static_bits(w, STAT_BYTES);
    end
  end

  assign rd_word = mem_q[idx][widx];

  always_comb begin
    we       = 1'b0;
    new_word = rd_word;
    if (step && hit) begin
      unique case (cmd)
        QC_WRITE:   begin we = 1'b1; new_word = stage_word; end
        QC_KEEPDYN: begin we = 1'b1; new_word = (stage_word & keep_mask) | (rd_word & ~keep_mask); end
        QC_CLEAR:   begin we = 1'b1; new_word = '0; end
        default:    begin we = 1'b0; new_word = rd_word; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (we) begin
      mem_q[idx][widx] <= new_word;
    end
  end

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hit && cmd == QC_CLEAR) |=> (mem_q[$past(idx)][$past(widx)] == '0));

  a_r6_dyn_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hit && cmd == QC_KEEPDYN) |=>
      (((mem_q[$past(idx)][$past(widx)] ^ $past(rd_word)) & ~$past(keep_mask)) == '0));

  a_r8_store_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!step || !hit) |=> $stable(mem_q));

endmodule

// File: rtl/qctx_access_unit.sv
module qctx_access_unit
  import qctx_pkg::*;
#(
  parameter int NUM_Q      = 8,
  parameter int WORDS      = 10,
  parameter int STAT_BYTES = 22,
  parameter int QID_W      = 14,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic [QID_W-1:0]  base_qid
);

  localparam int IDX_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int CNT_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CTL_ADDR = WORDS;

  logic              busy, op_hit, ctl_we, load_en, is_ctl;
  logic [CMD_W-1:0]  op_cmd;
  logic [IDX_W-1:0]  op_idx;
  logic [CNT_W-1:0]  word_idx;
  logic [31:0]       ctl_rdata, stage_host, stage_op, store_rd;

  assign is_ctl  = (32'(host_addr) == 32'(CTL_ADDR));
  assign ctl_we  = host_we & is_ctl;
  assign load_en = busy & op_hit & (op_cmd == QC_READ);

  qctx_ctrl #(
    .NUM_Q(NUM_Q), .WORDS(WORDS), .QID_W(QID_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(host_wdata),
    .base_qid(base_qid), .busy(busy), .op_cmd(op_cmd), .op_hit(op_hit),
    .op_idx(op_idx), .word_idx(word_idx), .ctl_rdata(ctl_rdata)
  );

  qctx_stage #(
    .WORDS(WORDS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_stage (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .busy(busy), .load_en(load_en),
    .load_idx(word_idx), .load_word(store_rd), .host_word(stage_host),
    .op_word(stage_op)
  );

  qctx_store #(
    .NUM_Q(NUM_Q), .WORDS(WORDS), .STAT_BYTES(STAT_BYTES),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .step(busy), .hit(op_hit), .cmd(op_cmd),
    .idx(op_idx), .widx(word_idx), .stage_word(stage_op), .rd_word(store_rd)
  );

  assign host_rdata = is_ctl ? ctl_rdata : stage_host;

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(host_addr) > 32'(CTL_ADDR)) |-> (host_rdata == '0));

endmodule

// File: tb/qctx_access_unit_tb.sv
module qctx_access_unit_tb;

  localparam int NQ = 4;
  localparam int NW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [13:0] base_qid = '0;

  always #10 clk = ~clk;  // 50 MHz

  qctx_access_unit #(.NUM_Q(NQ), .WORDS(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .base_qid(base_qid)
  );

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t       sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  logic [31:0] mdl [NQ][NW];
  logic [31:0] stg [NW];

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (host_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %08h expected %08h", it.req, host_rdata, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic hw_write(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [31:0] e, input string r);
    item_t it;
    host_addr = a;
    it.exp = e; it.req = r;
    sb.push_back(it);
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] smask(input int w);
    if (w < 5) return 32'hFFFF_FFFF;
    if (w == 5) return 32'h0000_FFFF;
    return 32'h0;
  endfunction

  task automatic stage_all(input logic [31:0] seed);
    for (int i = 0; i < NW; i++) begin
      stg[i] = seed ^ (32'h0101_0101 * (i + 1));
      hw_write(4'(i), stg[i]);
    end
  endtask

  task automatic exec(input int cmd, input int q);
    hw_write(4'(NW), (32'(1) << 19) | (32'(cmd) << 16) | 32'(q));
    repeat (NW + 2) @(posedge clk);
    #1;
  endtask

  task automatic check_stage(input string r);
    for (int i = 0; i < NW; i++) do_read(4'(i), stg[i], r);
  endtask

  task automatic read_entry(input int q, input string r);
    exec(0, q);
    for (int i = 0; i < NW; i++) stg[i] = mdl[q][i];
    check_stage(r);
  endtask

  initial begin
    for (int q = 0; q < NQ; q++)
      for (int i = 0; i < NW; i++) mdl[q][i] = '0;
    for (int i = 0; i < NW; i++) stg[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 reset state
    do_read(4'(NW), 32'h0, "R2 control after reset");
    check_stage("R2 stage after reset");
    do_read(4'd12, 32'h0, "R2 unmapped address");
    read_entry(2, "R2 entry zero after reset");

    // R3 full write then R5 read back
    stage_all(32'hA5C3_0001);
    for (int i = 0; i < NW; i++) mdl[1][i] = stg[i];
    exec(1, 1);
    stage_all(32'h0);
    read_entry(1, "R3/R5 full write read back");

    // R4 busy span and lock, R1 readback fields
    stage_all(32'h5E11_7700);
    for (int i = 0; i < NW; i++) mdl[2][i] = stg[i];
    hw_write(4'(NW), (32'(1) << 19) | (32'(1) << 16) | 32'd2);
    do_read(4'(NW), 32'h0009_0002, "R4 busy right after execute");
    hw_write(4'd2, 32'hDEAD_BEEF);
    repeat (6) @(posedge clk);
    do_read(4'(NW), 32'h0009_0002, "R4 busy in tenth cycle");
    do_read(4'(NW), 32'h0001_0002, "R4 idle after ten cycles");
    do_read(4'd2, stg[2], "R4 stage write while busy ignored");
    stage_all(32'h0);
    read_entry(2, "R4 entry unaffected by busy write");

    // R6 partial write keeps dynamic bits
    stage_all(32'h3C3C_9999);
    for (int i = 0; i < NW; i++)
      mdl[1][i] = (stg[i] & smask(i)) | (mdl[1][i] & ~smask(i));
    exec(4, 1);
    read_entry(1, "R6 partial write");

    // R7 clear
    exec(3, 1);
    for (int i = 0; i < NW; i++) mdl[1][i] = '0;
    stage_all(32'h7777_1234);
    read_entry(1, "R7 clear zeroes entry");

    // R8 undefined command on queue 2
    stage_all(32'h0BAD_0C0D);
    exec(2, 2);
    check_stage("R8 undefined keeps stage");
    exec(6, 2);
    check_stage("R8 undefined code 6 keeps stage");
    read_entry(2, "R8 undefined keeps entry");

    // R9 base offset: base 2 + local 1 -> entry 3
    base_qid = 14'd2;
    stage_all(32'h1357_2468);
    for (int i = 0; i < NW; i++) mdl[3][i] = stg[i];
    exec(1, 1);
    base_qid = 14'd0;
    stage_all(32'h0);
    read_entry(3, "R9 base plus index");
    read_entry(1, "R9 local entry untouched by offset write");

    // R9 out of range: local 5 with four entries
    stage_all(32'hFACE_0055);
    exec(1, 5);
    exec(0, 5);
    check_stage("R9 out of range read keeps stage");
    read_entry(1, "R9 out of range write no alias");

    // R1 control write with execute clear
    hw_write(4'(NW), (32'(1) << 16) | 32'd3);
    do_read(4'(NW), 32'h0001_0003, "R1 fields recorded, not busy");
    stage_all(32'h0);
    read_entry(3, "R1 no operation without execute");

    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule